// File: doc/BRIEF.md
# Legacy Video and ISA Alias Configuration Checker

This block watches the bridge-control settings of a set of PCI Express ports and flags software configurations that would give conflicting routes for the legacy video window and the ISA-aliased I/O ranges. For each port it receives a video-window enable, an ISA alias enable, a video decode-width select (10-bit or 16-bit aliasing), an I/O-space enable, and the 16-bit I/O base and limit of the port's window. No transaction goes through the block. It only judges the configuration.

The rules are checked across ports. At most one port may claim the video window. The port that does claim it determines which other ports must have ISA aliasing turned on. With 10-bit decoding, every other port that has a usable I/O window must have it. With 16-bit decoding, only the ports whose usable window starts at address 0000h must have it. A strict mode replaces both of these rules with a blanket rule. In that mode, when any port claims the video window, every other port must have ISA aliasing on. Violations are collected in a sticky cause register with one bit per rule. Software clears each bit by writing a one to it, through a pulse input.

Top module: `legacy_io_rule_chk`

## Requirements
- R1: Cause bit 0 (multiple video owners) is raised when two or more ports have their video-window enable set at the same time.
- R2: A port's I/O window counts as usable only when its I/O-space enable is 1 and its limit is greater than or equal to its base, compared as unsigned values. A window whose base equals its limit is usable. Port p's base and limit sit in bits [p*16 +: 16] of the flat base and limit inputs.
- R3: With strict mode off, cause bit 1 (10-bit alias conflict) is raised when some port x has video enable set and decode-width select 0, and another port y with a usable window has ISA enable 0. Port x's own ISA enable has no effect.
- R4: With strict mode off, cause bit 2 (16-bit alias conflict) is raised when some port x has video enable set and decode-width select 1, and another port y has a usable window with base 0000h and ISA enable 0. A port y whose base is not 0000h never raises this bit.
- R5: With strict mode on, cause bit 3 (blanket alias conflict) is raised when some port x has video enable set and any other port has ISA enable 0, whatever that port's window. In strict mode, bits 1 and 2 are never raised.
- R6: When no port has video enable set, none of cause bits 1, 2 or 3 is raised, whatever the ISA enables and windows are.
- R7: A cause bit is set at the clock edge that samples a violating configuration. It stays set after the violation goes away, until a cycle in which its clear bit is 1. If a violation and a clear of the same bit occur in the same cycle, the bit stays set.
- R8: The error flag equals the OR of the four sticky cause bits. A synchronous reset clears all cause bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_strict | input | 1 | Selects the blanket alias rule in place of the per-window rules |
| port_vga_en | input | NPORT | Video-window enable, one bit per port |
| port_isa_en | input | NPORT | ISA alias enable, one bit per port |
| port_dec16 | input | NPORT | Decode-width select per port: 1 = 16-bit, 0 = 10-bit |
| port_io_en | input | NPORT | I/O-space enable per port |
| port_io_base | input | NPORT*AW | Flat I/O window bases, port p at [p*AW +: AW] |
| port_io_limit | input | NPORT*AW | Flat I/O window limits, port p at [p*AW +: AW] |
| err_clr | input | 4 | Write-one-to-clear pulse for each cause bit |
| err_flag | output | 1 | Sticky programming-error flag |
| err_cause | output | 4 | Sticky causes: [0] multiple owners, [1] 10-bit alias, [2] 16-bit alias, [3] blanket alias |

## Verification
The hardest situations to reach are the boundary windows. One is a peer whose base equals its limit. Another is a peer whose window starts at 0000h but whose I/O-space enable is off. Both change the verdict of the 16-bit rule, and both are rare when values are drawn at random. The sweep therefore draws bases and limits from a small pool of edge values (0000h, 0001h, 1000h, FFFFh) mixed with random values, and holds every clear bit high, so that each cycle shows the verdict on that cycle's configuration alone. Directed sequences then cover the equal-bounds and disabled-window peers, the hold-and-clear behaviour of the sticky register, and a clear that collides with a new violation.

// File: rtl/legacy_chk_pkg.sv
package legacy_chk_pkg;

    localparam int CAUSE_W = 4;

    typedef enum int unsigned {
        C_MULTI = 0,
        C_WIDE  = 1,
        C_LOW   = 2,
        C_ALL   = 3
    } cause_idx_e;

    typedef logic [CAUSE_W-1:0] cause_t;

    // Classified view of one port, independent of address width
    typedef struct packed {
        logic vga;    // claims the video window
        logic isa;    // ISA aliasing on
        logic dec16;  // 16-bit decode select
        logic valid;  // usable I/O window
        logic low;    // usable window starting at zero
    } port_view_t;

    function automatic cause_t merge_cause(input cause_t held, input cause_t clr,
                                           input cause_t fresh);
        return (held & ~clr) | fresh;
    endfunction

endpackage

// File: rtl/port_window_eval.sv
module port_window_eval
    import legacy_chk_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          vga_en,
    input  logic          isa_en,
    input  logic          dec16,
    input  logic          io_en,
    input  logic [AW-1:0] io_base,
    input  logic [AW-1:0] io_limit,
    output port_view_t    view
);

    logic win_ok;
    logic base_zero;

    always_comb begin
        win_ok    = io_en && (io_limit >= io_base);
        base_zero = (io_base == '0);
        view.vga   = vga_en;
        view.isa   = isa_en;
        view.dec16 = dec16;
        view.valid = win_ok;
        view.low   = win_ok && base_zero;
    end

endmodule

// File: rtl/peer_rule_eval.sv
module peer_rule_eval
    import legacy_chk_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  port_view_t view [NPORT],
    input  logic       strict,
    output cause_t     cause_now
);

    localparam int CW = $clog2(NPORT + 1);

    logic [NPORT-1:0] wide_x;
    logic [NPORT-1:0] low_x;
    logic [NPORT-1:0] all_x;
    logic [CW-1:0]    owner_cnt;

    always_comb begin
        owner_cnt = '0;
        for (int p = 0; p < NPORT; p++) begin
            owner_cnt = owner_cnt + CW'(view[p].vga);
        end
    end

    for (genvar gx = 0; gx < NPORT; gx++) begin : g_owner
        logic hit_wide;
        logic hit_low;
        logic hit_all;

        always_comb begin
            hit_wide = 1'b0;
            hit_low  = 1'b0;
            hit_all  = 1'b0;
            for (int y = 0; y < NPORT; y++) begin
                if (y != gx && !view[y].isa) begin
                    hit_all = 1'b1;
                    if (view[y].valid) hit_wide = 1'b1;
                    if (view[y].low)   hit_low  = 1'b1;
                end
            end
        end

        assign wide_x[gx] = view[gx].vga && !view[gx].dec16 && hit_wide;
        assign low_x[gx]  = view[gx].vga &&  view[gx].dec16 && hit_low;
        assign all_x[gx]  = view[gx].vga && hit_all;
    end

    always_comb begin
        cause_now          = '0;
        cause_now[C_MULTI] = (owner_cnt > CW'(1));
        cause_now[C_WIDE]  = !strict && (|wide_x);
        cause_now[C_LOW]   = !strict && (|low_x);
        cause_now[C_ALL]   =  strict && (|all_x);
    end

endmodule

// File: rtl/sticky_cause_reg.sv
module sticky_cause_reg
    import legacy_chk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t fresh,
    input  cause_t clr,
    output cause_t held
);

    always_ff @(posedge clk) begin
        if (rst) held <= '0;
        else     held <= merge_cause(held, clr, fresh);
    end

endmodule

// File: rtl/legacy_io_rule_chk.sv
module legacy_io_rule_chk
    import legacy_chk_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int AW    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                chk_strict,
    input  logic [NPORT-1:0]    port_vga_en,
    input  logic [NPORT-1:0]    port_isa_en,
    input  logic [NPORT-1:0]    port_dec16,
    input  logic [NPORT-1:0]    port_io_en,
    input  logic [NPORT*AW-1:0] port_io_base,
    input  logic [NPORT*AW-1:0] port_io_limit,
    input  logic [3:0]          err_clr,
    output logic                err_flag,
    output logic [3:0]          err_cause
);

    port_view_t views [NPORT];
    cause_t     cause_now;
    cause_t     cause_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_window_eval #(.AW(AW)) u_win (
            .vga_en   (port_vga_en[p]),
            .isa_en   (port_isa_en[p]),
            .dec16    (port_dec16[p]),
            .io_en    (port_io_en[p]),
            .io_base  (port_io_base[p*AW +: AW]),
            .io_limit (port_io_limit[p*AW +: AW]),
            .view     (views[p])
        );
    end

    peer_rule_eval #(.NPORT(NPORT)) u_rules (
        .view      (views),
        .strict    (chk_strict),
        .cause_now (cause_now)
    );

    sticky_cause_reg u_sticky (
        .clk   (clk),
        .rst   (rst),
        .fresh (cause_now),
        .clr   (err_clr),
        .held  (cause_q)
    );

    assign err_cause = cause_q;
    assign err_flag  = |cause_q;

endmodule

// File: rtl/legacy_io_rule_chk_sva.sv
module legacy_io_rule_chk_sva #(
    parameter int NPORT = 4,
    parameter int AW    = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             chk_strict,
    input logic [NPORT-1:0] port_vga_en,
    input logic [3:0]       err_clr,
    input logic             err_flag,
    input logic [3:0]       err_cause
);

    // R1: two or more owners always mark bit 0 on the next edge
    p_multi_set_r1: assert property (@(posedge clk) disable iff (rst)
        ($countones(port_vga_en) > 1) |=> err_cause[0]);

    // R1: with one owner or none, bit 0 can only appear if it is already held
    p_multi_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ($countones(port_vga_en) <= 1 && !err_cause[0]) |=> !err_cause[0]);

    // R5: strict mode never raises the per-window causes
    p_strict_no_window_r5: assert property (@(posedge clk) disable iff (rst)
        (chk_strict && err_cause[2:1] == 2'b00) |=> (err_cause[2:1] == 2'b00));

    // R6: without an owner no alias cause appears
    p_no_owner_r6: assert property (@(posedge clk) disable iff (rst)
        (port_vga_en == '0 && err_cause[3:1] == 3'b000) |=> (err_cause[3:1] == 3'b000));

    // R7: held bits that are not being cleared remain held
    p_sticky_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (err_cause != 4'b0000) |=>
            ((err_cause & $past(err_cause & ~err_clr)) == $past(err_cause & ~err_clr)));

    // R8: the flag follows the cause bits
    p_flag_or_r8: assert property (@(posedge clk) disable iff (rst)
        err_flag == (err_cause != 4'b0000));

endmodule

bind legacy_io_rule_chk legacy_io_rule_chk_sva #(.NPORT(NPORT), .AW(AW)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .chk_strict  (chk_strict),
    .port_vga_en (port_vga_en),
    .err_clr     (err_clr),
    .err_flag    (err_flag),
    .err_cause   (err_cause)
);

// File: tb/sim_legacy_io_rule_chk.sv
module sim_legacy_io_rule_chk;

    localparam int N  = 4;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strict = 1'b0;
    logic [N-1:0]  vga = '0, isa = '0, d16 = '0, ioe = '0;
    logic [AW-1:0] base [N];
    logic [AW-1:0] lim  [N];
    logic [N*AW-1:0] base_flat, lim_flat;
    logic [3:0]    clr = 4'h0;
    logic          flag;
    logic [3:0]    cause;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int p = 0; p < N; p++) begin
            base_flat[p*AW +: AW] = base[p];
            lim_flat[p*AW +: AW]  = lim[p];
        end
    end

    legacy_io_rule_chk #(.NPORT(N), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .chk_strict(strict),
        .port_vga_en(vga), .port_isa_en(isa), .port_dec16(d16), .port_io_en(ioe),
        .port_io_base(base_flat), .port_io_limit(lim_flat),
        .err_clr(clr), .err_flag(flag), .err_cause(cause)
    );

    // Behavioural rule model, written from the requirements
    function automatic logic [3:0] model();
        logic [3:0] r = 4'h0;
        int owners = 0;
        for (int x = 0; x < N; x++) begin
            if (vga[x]) owners++;
            if (vga[x]) begin
                for (int y = 0; y < N; y++) begin
                    if (y != x && !isa[y]) begin
                        logic usable = ioe[y] && (lim[y] >= base[y]);
                        if (strict) r[3] = 1'b1;
                        else if (!d16[x] && usable) r[1] = 1'b1;
                        else if (d16[x] && usable && base[y] == 16'h0000) r[2] = 1'b1;
                    end
                end
            end
        end
        if (owners >= 2) r[0] = 1'b1;
        return r;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] pick();
        case ($urandom % 5)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h1000;
            3: return 16'hFFFF;
            default: return AW'($urandom);
        endcase
    endfunction

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic quiet_cfg();
        vga = '0; isa = '1; d16 = '0; ioe = '0; strict = 1'b0;
        for (int p = 0; p < N; p++) begin base[p] = 16'h2000; lim[p] = 16'h2FFF; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        quiet_cfg();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        check("R8 reset cause", cause, 4'h0);
        check("R8 reset flag", {3'b0, flag}, 4'h0);

        // R6: no owner, every peer usable with ISA off
        ioe = '1; isa = '0; base[0] = 16'h0000; lim[0] = 16'h0000;
        settle();
        check("R6 no owner", cause, 4'h0);

        // R2/R3: equal bounds are usable, 10-bit owner on port 0
        quiet_cfg(); vga = 4'b0001; isa = 4'b1101; ioe = 4'b0010;
        base[1] = 16'h3000; lim[1] = 16'h3000; clr = 4'hF;
        settle();
        check("R2 R3 equal bounds", cause, 4'b0010);
        // R2: limit below base is unusable
        lim[1] = 16'h2FFF;
        settle();
        check("R2 inverted window", cause, 4'b0000);
        // R2: disabled I/O space is unusable
        lim[1] = 16'h3000; ioe = 4'b0000;
        settle();
        check("R2 io disabled", cause, 4'b0000);
        // R3: owner's own ISA bit is irrelevant
        ioe = 4'b0001; isa = 4'b1110; base[0] = 16'h0000; lim[0] = 16'hFFFF;
        settle();
        check("R3 owner self", cause, 4'b0000);

        // R4: 16-bit owner, peer at base 0 vs base 1
        quiet_cfg(); vga = 4'b0100; d16 = 4'b0100; isa = 4'b0111; ioe = 4'b1000;
        base[3] = 16'h0001; lim[3] = 16'h0FFF;
        settle();
        check("R4 nonzero base", cause, 4'b0000);
        base[3] = 16'h0000; lim[3] = 16'h0000;
        settle();
        check("R4 zero base equal bounds", cause, 4'b0100);
        ioe = 4'b0000;
        settle();
        check("R4 zero base disabled", cause, 4'b0000);

        // R5: strict mode ignores windows
        strict = 1'b1;
        settle();
        check("R5 blanket", cause, 4'b1000);
        isa = 4'b1111;
        settle();
        check("R5 blanket satisfied", cause, 4'b0000);

        // R7: sticky hold, clear, and set-over-clear
        quiet_cfg(); clr = 4'h0; vga = 4'b0011;
        settle();
        check("R7 set", cause, 4'b0001);
        vga = 4'b0000;
        repeat (3) settle();
        check("R7 hold", cause, 4'b0001);
        check("R8 flag held", {3'b0, flag}, 4'h1);
        clr = 4'b0001;
        settle();
        check("R7 cleared", cause, 4'b0000);
        vga = 4'b1010;
        settle();
        check("R7 set beats clear", cause, 4'b0001);
        rst = 1'b1;
        settle();
        rst = 1'b0;
        check("R8 reset clears", cause, 4'b0000);

        // Sweep: every clear bit held so each cycle shows that cycle's verdict
        clr = 4'hF;
        for (int it = 0; it < 3000; it++) begin
            case ($urandom % 8)
                0: vga = '0;
                1, 2, 3, 4, 5: vga = N'(1) << ($urandom % N);
                default: vga = N'($urandom);
            endcase
            isa = N'($urandom); d16 = N'($urandom); ioe = N'($urandom);
            strict = (($urandom % 4) == 0);
            for (int p = 0; p < N; p++) begin
                base[p] = pick();
                lim[p]  = (($urandom % 4) == 0) ? base[p] : pick();
            end
            settle();
            check("R1,R3,R4,R5,R6 sweep", cause, model());
            check("R8 sweep flag", {3'b0, flag}, {3'b0, |model()});
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule